// File: doc/BRIEF.md
# LCD Controller Instruction Decoder

This block turns the byte stream of a small matrix LCD controller into register updates and strobes. Each byte arrives with a valid flag and a data/command flag. A data byte becomes a write strobe toward the display RAM address generator. A command byte is decoded against a page bit held in the function-set register. The page bit picks which of two command sets is currently legal. A command that belongs to the other page is dropped without effect.

The function-set register holds four bits: power-down, vertical addressing, horizontal mirror and the page bit. Legal commands load the display mode, the charge-pump stage count, the vertical-mirror bit, the two row-block mirror bits, the bias code and the contrast code. They also issue clamped X and Y address loads. All results are registered and appear one clock after the byte is accepted.

Top module: `lcd_instr_dec`

## Requirements
- R1: After reset the outputs are: pd_o=1, page_o=0, vert_o=0, mx_o=0, mode_o=00 (blank), my_o=trs_o=brs_o=0, stages_o=0, bias_o=0, vop_o=0, and no strobe is active.
- R2: A command byte 0010_abcd is accepted on either page. It sets pd_o=a, vert_o=b, mx_o=c and page_o=d one cycle later.
- R3: A byte with dc_i=1 pulses wr_o for one cycle, one cycle later, with wr_data_o equal to the byte. This holds on either page and in power-down.
- R4: On page 0, byte 0000_10de sets mode_o={d,e}. The encodings are 00 blank, 10 normal, 01 all on and 11 inverse. On page 0, byte 0000_01st sets stages_o={s,t}.
- R5: On page 1, byte 0000_1mtb sets my_o=m, trs_o=t and brs_o=b; my_o takes the new value on the next cycle. On page 1, byte 0001_0xyz sets bias_o=xyz, and byte 1vvv_vvvv sets vop_o=vvv_vvvv.
- R6: A command that is not legal on the current page changes no register and raises no strobe. Byte 1xxx_xxxx on page 1 raises no X load.
- R7: On page 0, byte 1xxx_xxxx pulses x_load_o for one cycle. x_val_o carries xxx_xxxx, clamped to 101.
- R8: On page 0, byte 0100_yyyy pulses y_load_o for one cycle. y_val_o carries yyyy, clamped to 8.
- R9: At most one of x_load_o, y_load_o and wr_o is high in any cycle. None of them is high in the cycle after a cycle with valid_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Byte present this cycle |
| dc_i | input | 1 | 1 = display data, 0 = command |
| byte_i | input | 8 | Command or data byte |
| pd_o | output | 1 | Power-down bit |
| vert_o | output | 1 | Vertical addressing selected |
| mx_o | output | 1 | Horizontal mirror bit |
| page_o | output | 1 | Command page bit |
| mode_o | output | 2 | Display mode {d,e} |
| stages_o | output | 2 | Charge-pump stage count |
| my_o | output | 1 | Vertical mirror bit |
| trs_o | output | 1 | Top row-block mirror |
| brs_o | output | 1 | Bottom row-block mirror |
| bias_o | output | 3 | Bias code |
| vop_o | output | 7 | Contrast code |
| x_load_o | output | 1 | X address load strobe |
| x_val_o | output | XW (7) | Clamped X address |
| y_load_o | output | 1 | Y address load strobe |
| y_val_o | output | YW (4) | Clamped Y address |
| wr_o | output | 1 | Data write strobe |
| wr_data_o | output | 8 | Data byte to write |

## Verification
Every result of this block is due on the first clock edge after the byte is presented: register bits, clamped addresses and one-cycle strobes alike. The bench drives each byte on a falling edge. Its behavioural model steps on the same rising edge as the design and compares the whole output set one nanosecond after that edge. Illegal-page commands are followed by an idle cycle, and the untouched registers and silent strobes are then read directly at the ports.

// File: rtl/lcd_dec_pkg.sv
package lcd_dec_pkg;
  typedef enum logic [3:0] {
    K_NONE, K_DATA, K_FUNC, K_DCTL, K_STAGES,
    K_SETY, K_SETX, K_DCFG, K_BIAS, K_VOP
  } cmd_kind_e;

  typedef enum logic [1:0] {
    MODE_BLANK   = 2'b00,
    MODE_ALLON   = 2'b01,
    MODE_NORMAL  = 2'b10,
    MODE_INVERSE = 2'b11
  } disp_mode_e;

  localparam logic [3:0] FUNC_OPC = 4'b0010;
endpackage

// File: rtl/lcd_cmd_classify.sv
module lcd_cmd_classify
  import lcd_dec_pkg::*;
(
  input  logic            valid_i,
  input  logic            dc_i,
  input  logic [7:0]      byte_i,
  input  logic            page_i,
  output cmd_kind_e       kind_o
);
  always_comb begin
    kind_o = K_NONE;
    if (valid_i) begin
      if (dc_i) begin
        kind_o = K_DATA;
      end else if (byte_i[7:4] == FUNC_OPC) begin
        kind_o = K_FUNC;
      end else if (!page_i) begin
        casez (byte_i)
          8'b0000_10??: kind_o = K_DCTL;
          8'b0000_01??: kind_o = K_STAGES;
          8'b0100_????: kind_o = K_SETY;
          8'b1???_????: kind_o = K_SETX;
          default:      kind_o = K_NONE;
        endcase
      end else begin
        casez (byte_i)
          8'b0000_1???: kind_o = K_DCFG;
          8'b0001_0???: kind_o = K_BIAS;
          8'b1???_????: kind_o = K_VOP;
          default:      kind_o = K_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
  import lcd_dec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cmd_kind_e  kind_i,
  input  logic [6:0] arg_i,
  output logic       pd_o,
  output logic       vert_o,
  output logic       mx_o,
  output logic       page_o,
  output logic [1:0] mode_o,
  output logic [1:0] stages_o,
  output logic       my_o,
  output logic       trs_o,
  output logic       brs_o,
  output logic [2:0] bias_o,
  output logic [6:0] vop_o
);
  logic       pd_q, vert_q, mx_q, page_q, my_q, trs_q, brs_q;
  logic [1:0] mode_q, stages_q;
  logic [2:0] bias_q;
  logic [6:0] vop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q     <= 1'b1;
      vert_q   <= 1'b0;
      mx_q     <= 1'b0;
      page_q   <= 1'b0;
      mode_q   <= MODE_BLANK;
      stages_q <= '0;
      my_q     <= 1'b0;
      trs_q    <= 1'b0;
      brs_q    <= 1'b0;
      bias_q   <= '0;
      vop_q    <= '0;
    end else begin
      case (kind_i)
        K_FUNC:   {pd_q, vert_q, mx_q, page_q} <= arg_i[3:0];
        K_DCTL:   mode_q   <= arg_i[1:0];
        K_STAGES: stages_q <= arg_i[1:0];
        K_DCFG:   {my_q, trs_q, brs_q} <= arg_i[2:0];
        K_BIAS:   bias_q   <= arg_i[2:0];
        K_VOP:    vop_q    <= arg_i[6:0];
        default:  ;
      endcase
    end
  end

  assign pd_o     = pd_q;
  assign vert_o   = vert_q;
  assign mx_o     = mx_q;
  assign page_o   = page_q;
  assign mode_o   = mode_q;
  assign stages_o = stages_q;
  assign my_o     = my_q;
  assign trs_o    = trs_q;
  assign brs_o    = brs_q;
  assign bias_o   = bias_q;
  assign vop_o    = vop_q;

  assert_func_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_FUNC) |=> ({pd_q, vert_q, mx_q, page_q} == $past(arg_i[3:0])));
  assert_page_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i != K_FUNC) |=> $stable(page_q));
  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i != K_DCTL) |=> $stable(mode_q));
  assert_mirror_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_DCFG) |=> (my_q == $past(arg_i[2])));
endmodule

// File: rtl/lcd_addr_strobe.sv
module lcd_addr_strobe
  import lcd_dec_pkg::*;
#(
  parameter int X_MAX = 101,
  parameter int Y_MAX = 8,
  localparam int XW = $clog2(X_MAX + 1),
  localparam int YW = $clog2(Y_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cmd_kind_e     kind_i,
  input  logic [7:0]    arg_i,
  output logic          x_load_o,
  output logic [XW-1:0] x_val_o,
  output logic          y_load_o,
  output logic [YW-1:0] y_val_o,
  output logic          wr_o,
  output logic [7:0]    wr_data_o
);
  localparam logic [6:0] XLIM = 7'(X_MAX);
  localparam logic [3:0] YLIM = 4'(Y_MAX);

  logic [6:0] x_cl;
  logic [3:0] y_cl;
  assign x_cl = (arg_i[6:0] > XLIM) ? XLIM : arg_i[6:0];
  assign y_cl = (arg_i[3:0] > YLIM) ? YLIM : arg_i[3:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_load_o  <= 1'b0;
      y_load_o  <= 1'b0;
      wr_o      <= 1'b0;
      x_val_o   <= '0;
      y_val_o   <= '0;
      wr_data_o <= '0;
    end else begin
      x_load_o <= (kind_i == K_SETX);
      y_load_o <= (kind_i == K_SETY);
      wr_o     <= (kind_i == K_DATA);
      if (kind_i == K_SETX) x_val_o <= x_cl[XW-1:0];
      if (kind_i == K_SETY) y_val_o <= y_cl[YW-1:0];
      if (kind_i == K_DATA) wr_data_o <= arg_i;
    end
  end

  assert_x_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_load_o |-> (int'(x_val_o) <= X_MAX));
  assert_y_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_load_o |-> (int'(y_val_o) <= Y_MAX));
  assert_strobe_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({x_load_o, y_load_o, wr_o}));
  assert_wr_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == K_DATA) |=> (wr_o && wr_data_o == $past(arg_i)));
endmodule

// File: rtl/lcd_instr_dec.sv
module lcd_instr_dec
  import lcd_dec_pkg::*;
#(
  parameter int X_MAX = 101,
  parameter int Y_MAX = 8,
  localparam int XW = $clog2(X_MAX + 1),
  localparam int YW = $clog2(Y_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          dc_i,
  input  logic [7:0]    byte_i,
  output logic          pd_o,
  output logic          vert_o,
  output logic          mx_o,
  output logic          page_o,
  output logic [1:0]    mode_o,
  output logic [1:0]    stages_o,
  output logic          my_o,
  output logic          trs_o,
  output logic          brs_o,
  output logic [2:0]    bias_o,
  output logic [6:0]    vop_o,
  output logic          x_load_o,
  output logic [XW-1:0] x_val_o,
  output logic          y_load_o,
  output logic [YW-1:0] y_val_o,
  output logic          wr_o,
  output logic [7:0]    wr_data_o
);
  cmd_kind_e kind;

  lcd_cmd_classify u_classify (
    .valid_i(valid_i),
    .dc_i   (dc_i),
    .byte_i (byte_i),
    .page_i (page_o),
    .kind_o (kind)
  );

  lcd_cfg_regs u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kind_i  (kind),
    .arg_i   (byte_i[6:0]),
    .pd_o    (pd_o),
    .vert_o  (vert_o),
    .mx_o    (mx_o),
    .page_o  (page_o),
    .mode_o  (mode_o),
    .stages_o(stages_o),
    .my_o    (my_o),
    .trs_o   (trs_o),
    .brs_o   (brs_o),
    .bias_o  (bias_o),
    .vop_o   (vop_o)
  );

  lcd_addr_strobe #(.X_MAX(X_MAX), .Y_MAX(Y_MAX)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .arg_i    (byte_i),
    .x_load_o (x_load_o),
    .x_val_o  (x_val_o),
    .y_load_o (y_load_o),
    .y_val_o  (y_val_o),
    .wr_o     (wr_o),
    .wr_data_o(wr_data_o)
  );

  assert_page1_no_xload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !dc_i && page_o) |=> !x_load_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(x_load_o || y_load_o || wr_o));
endmodule

// File: tb/tb_lcd_instr_dec.sv
module tb_lcd_instr_dec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic       dc = 1'b0;
  logic [7:0] byt = 8'h00;

  logic       pd, vert, mx, page, my, trs, brs, xl, yl, wr;
  logic [1:0] mode, stages;
  logic [2:0] bias;
  logic [6:0] vop, xv;
  logic [3:0] yv;
  logic [7:0] wd;

  int tests = 0;
  int fails = 0;

  // reference model state
  int m_pd = 1, m_vert = 0, m_mx = 0, m_page = 0, m_mode = 0, m_stages = 0;
  int m_my = 0, m_trs = 0, m_brs = 0, m_bias = 0, m_vop = 0;
  int m_xl = 0, m_xv = 0, m_yl = 0, m_yv = 0, m_wr = 0, m_wd = 0;

  always #5 clk = ~clk;

  lcd_instr_dec dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .dc_i(dc), .byte_i(byt),
    .pd_o(pd), .vert_o(vert), .mx_o(mx), .page_o(page), .mode_o(mode),
    .stages_o(stages), .my_o(my), .trs_o(trs), .brs_o(brs), .bias_o(bias),
    .vop_o(vop), .x_load_o(xl), .x_val_o(xv), .y_load_o(yl), .y_val_o(yv),
    .wr_o(wr), .wr_data_o(wd)
  );

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    int b;
    b = int'(byt);
    m_xl = 0; m_yl = 0; m_wr = 0;
    if (!rst_n) begin
      m_pd = 1; m_vert = 0; m_mx = 0; m_page = 0; m_mode = 0; m_stages = 0;
      m_my = 0; m_trs = 0; m_brs = 0; m_bias = 0; m_vop = 0;
      m_xv = 0; m_yv = 0; m_wd = 0;
    end else if (valid) begin
      if (dc) begin
        m_wr = 1; m_wd = b;
      end else if (b / 16 == 2) begin
        m_pd = (b >> 3) & 1; m_vert = (b >> 2) & 1; m_mx = (b >> 1) & 1; m_page = b & 1;
      end else if (m_page == 0) begin
        if (b / 4 == 2) m_mode = b % 4;
        else if (b / 4 == 1) m_stages = b % 4;
        else if (b / 16 == 4) begin m_yl = 1; m_yv = (b % 16 > 8) ? 8 : b % 16; end
        else if (b >= 128) begin m_xl = 1; m_xv = (b - 128 > 101) ? 101 : b - 128; end
      end else begin
        if (b / 8 == 1) begin m_my = (b >> 2) & 1; m_trs = (b >> 1) & 1; m_brs = b & 1; end
        else if (b / 8 == 2) m_bias = b % 8;
        else if (b >= 128) m_vop = b - 128;
      end
    end
  endtask

  task automatic compare_all();
    chk("R2", "pd", int'(pd), m_pd);
    chk("R2", "vert", int'(vert), m_vert);
    chk("R2", "mx", int'(mx), m_mx);
    chk("R2", "page", int'(page), m_page);
    chk("R4", "mode", int'(mode), m_mode);
    chk("R4", "stages", int'(stages), m_stages);
    chk("R5", "my", int'(my), m_my);
    chk("R5", "trs", int'(trs), m_trs);
    chk("R5", "brs", int'(brs), m_brs);
    chk("R5", "bias", int'(bias), m_bias);
    chk("R5", "vop", int'(vop), m_vop);
    chk("R7", "x_load", int'(xl), m_xl);
    chk("R7", "x_val", int'(xv), m_xv);
    chk("R8", "y_load", int'(yl), m_yl);
    chk("R8", "y_val", int'(yv), m_yv);
    chk("R3", "wr", int'(wr), m_wr);
    chk("R3", "wr_data", int'(wd), m_wd);
    chk("R9", "strobe count", int'(xl) + int'(yl) + int'(wr), m_xl + m_yl + m_wr);
  endtask

  always @(posedge clk) begin
    model_step();
    #1 compare_all();
  end

  task automatic send(logic d, logic [7:0] b);
    @(negedge clk);
    valid = 1'b1; dc = d; byt = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0; byt = 8'(i * 37 + 11);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pd", int'(pd), 1);
    chk("R1", "page", int'(page), 0);
    chk("R1", "mode", int'(mode), 0);
    chk("R1", "strobes", int'(xl) + int'(yl) + int'(wr), 0);
    rst_n = 1'b1;
    idle(2);

    // R3 data in power-down on page 0
    send(1'b1, 8'hA5);
    idle(1);
    chk("R3", "wr in power-down", int'(wr), 1);
    chk("R3", "wr_data", int'(wd), 8'hA5);

    // R4 display modes and stages on page 0
    send(1'b0, 8'b0000_1010); send(1'b0, 8'b0000_1001);
    send(1'b0, 8'b0000_1011); send(1'b0, 8'b0000_1000);
    send(1'b0, 8'b0000_0110);
    idle(1);
    chk("R4", "mode blank", int'(mode), 0);
    chk("R4", "stages", int'(stages), 2);

    // R7 / R8 address loads with clamp
    send(1'b0, 8'h80); send(1'b0, 8'h80 | 8'd50); send(1'b0, 8'h80 | 8'd101);
    send(1'b0, 8'h80 | 8'd102);
    idle(1);
    chk("R7", "x clamp 102", int'(xv), 101);
    send(1'b0, 8'hFF);
    idle(1);
    chk("R7", "x clamp 127", int'(xv), 101);
    send(1'b0, 8'h40); send(1'b0, 8'h48); send(1'b0, 8'h49);
    idle(1);
    chk("R8", "y clamp 9", int'(yv), 8);
    send(1'b0, 8'h4F);
    idle(1);
    chk("R8", "y clamp 15", int'(yv), 8);

    // R6 page-1 commands on page 0 are dropped
    send(1'b0, 8'b0001_0101); send(1'b0, 8'b0000_1111);
    idle(1);
    chk("R6", "bias untouched", int'(bias), 0);
    chk("R6", "my untouched", int'(my), 0);
    chk("R6", "mode untouched", int'(mode), 0);

    // R2 switch to page 1, power up
    send(1'b0, 8'b0010_0001);
    idle(1);
    chk("R2", "page", int'(page), 1);
    chk("R2", "pd", int'(pd), 0);

    // R5 page 1 commands
    send(1'b0, 8'b0000_1101);
    idle(1);
    chk("R5", "my immediate", int'(my), 1);
    chk("R5", "brs", int'(brs), 1);
    send(1'b0, 8'b0001_0110); send(1'b0, 8'hC3);
    idle(1);
    chk("R5", "bias", int'(bias), 6);
    chk("R5", "vop", int'(vop), 8'h43);
    chk("R6", "no x load on page 1", int'(xl), 0);

    // R6 page-0 commands on page 1 are dropped
    send(1'b0, 8'h45); send(1'b0, 8'b0000_0111);
    idle(1);
    chk("R6", "y_load silent", int'(yl), 0);
    chk("R6", "y_val untouched", int'(yv), 8);
    chk("R6", "stages untouched", int'(stages), 2);

    // R3 data on page 1, then back to page 0 with vert/mx
    send(1'b1, 8'h3C);
    send(1'b0, 8'b0010_0110);
    idle(1);
    chk("R2", "vert", int'(vert), 1);
    chk("R2", "page back to 0", int'(page), 0);

    // R9 idle then mixed stream
    idle(3);
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
      valid = lfsr[0] | lfsr[1];
      dc = lfsr[2] & lfsr[3];
      byt = (lfsr[5:4] == 2'b00) ? {4'b0010, lfsr[11:8]} : lfsr[15:8];
    end
    // mid-stream reset returns to R1 state
    @(negedge clk);
    valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "pd after reset", int'(pd), 1);
    chk("R1", "vop after reset", int'(vop), 0);
    rst_n = 1'b1;
    idle(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule